// File: doc/BRIEF.md
# Power-Pulsing Front-End Sequencer

This block times the power cycling of a pixel chip's analog front end. Collisions come in short, sparse bunch trains, so the front end is kept in a low-power idle state for almost the whole period. It is brought to its operating bias only around each train. When a train-start strobe arrives, the sequencer raises a bias-enable for a programmed window. A programmed number of cycles after the bias turns on, once the preamplifiers have had time to settle, it opens an acquisition shutter for a programmed width. When the window ends it drops the bias and waits for the next train.

Three cycle counts set the sequence: the settling delay, the shutter width and the bias window. They are captured through a load strobe, and only while the sequencer is idle. A train-start strobe that arrives during an active sequence does not restart it. Instead it sets a sticky overrun flag, so that lost trains can be seen.

Top module: `fe_pulse_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `bias_en`, `shutter`, `busy` and `overrun` are all low. The sequencer then waits for a `train_start` strobe.
- R2: A `train_start` sampled high while idle makes `bias_en` and `busy` go high on the following cycle. They stay high for exactly `win_len` consecutive cycles. A window of 0 acts as a window of 1.
- R3: Number the bias-on cycles from 0, where 0 is the first cycle with `bias_en` high. `shutter` is high from cycle `settle_len` for `shut_len` cycles.
- R4: When `settle_len + shut_len` exceeds the window, the shutter closes together with the bias. It is never high after the last bias-on cycle.
- R5: A `shut_len` of 0, or a `settle_len` not below the window, produces no shutter at all, while the bias window still runs.
- R6: A `train_start` sampled high while `busy` is high is ignored: the running sequence is neither restarted nor extended. `overrun` goes high the next cycle and stays high until reset.
- R7: `cfg_load` sampled high while idle captures all three lengths. While `busy`, it is ignored, and the next sequence still uses the earlier values.
- R8: If `cfg_load` and `train_start` are sampled high in the same idle cycle, the sequence that starts uses the newly loaded lengths.
- R9: A `train_start` in the first cycle after `busy` falls starts a new sequence without setting `overrun`.
- R10: `shutter` is never high unless `bias_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| train_start | input | 1 | Bunch-train start strobe |
| cfg_load | input | 1 | Capture the three lengths (honoured only while idle) |
| settle_len | input | CNT_W | Cycles from bias-on to shutter open |
| shut_len | input | CNT_W | Shutter width in cycles |
| win_len | input | CNT_W | Bias-on window in cycles |
| bias_en | output | 1 | Front-end bias at operating level |
| shutter | output | 1 | Acquisition shutter open |
| busy | output | 1 | Sequence in progress |
| overrun | output | 1 | Sticky flag: a train start was dropped |

## Verification
On every cycle, the assertions check that the shutter lies inside the bias window and that a bias turn-on always follows a strobe. They also check that a strobe during a sequence raises the overrun flag, which then never clears, and that the captured lengths hold still for the whole of a sequence. The exact opening and closing cycles of the shutter can only be shown by the bench's scenarios: clipping, an empty shutter, the degenerate zero window, a load ignored while busy, a load together with a start, and back-to-back trains. The bench compares each of these cycle by cycle against a model of the counts.

// File: rtl/fe_pp_pkg.sv
package fe_pp_pkg;
  typedef enum logic {
    PP_IDLE = 1'b0,
    PP_RUN  = 1'b1
  } pp_state_e;
endpackage

// File: rtl/fe_pp_cfg_regs.sv
module fe_pp_cfg_regs #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] settle_in,
  input  logic [CNT_W-1:0] shut_in,
  input  logic [CNT_W-1:0] win_in,
  output logic [CNT_W-1:0] settle_q,
  output logic [CNT_W-1:0] shut_q,
  output logic [CNT_W-1:0] win_q
);
  localparam logic [CNT_W-1:0] MIN_WIN = CNT_W'(1);

  logic [CNT_W-1:0] settle_n, shut_n, win_n;
  logic [CNT_W-1:0] win_clamped;

  // a zero-length window would never end; treat it as one cycle
  assign win_clamped = (win_in == '0) ? MIN_WIN : win_in;

  always_comb begin
    settle_n = settle_q;
    shut_n   = shut_q;
    win_n    = win_q;
    if (load_en) begin
      settle_n = settle_in;
      shut_n   = shut_in;
      win_n    = win_clamped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
      shut_q   <= '0;
      win_q    <= MIN_WIN;
    end else if (load_en) begin
      settle_q <= settle_n;
      shut_q   <= shut_n;
      win_q    <= win_n;
    end
  end
endmodule

// File: rtl/fe_pp_ctrl.sv
module fe_pp_ctrl
  import fe_pp_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [CNT_W-1:0] win_len_q,
  output logic             run,
  output logic [CNT_W-1:0] phase
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  pp_state_e        state_q, state_n;
  logic [CNT_W-1:0] phase_n;
  logic             last_cycle;
  logic             ce;

  assign last_cycle = (phase == (win_len_q - ONE));
  assign ce         = (state_q == PP_RUN) || start_req;

  always_comb begin
    state_n = state_q;
    phase_n = phase;
    unique case (state_q)
      PP_IDLE: begin
        if (start_req) begin
          state_n = PP_RUN;
          phase_n = '0;
        end
      end
      PP_RUN: begin
        if (last_cycle) begin
          state_n = PP_IDLE;
          phase_n = '0;
        end else begin
          phase_n = phase + ONE;
        end
      end
      default: begin
        state_n = PP_IDLE;
        phase_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PP_IDLE;
      phase   <= '0;
    end else if (ce) begin
      state_q <= state_n;
      phase   <= phase_n;
    end
  end

  assign run = (state_q == PP_RUN);
endmodule

// File: rtl/fe_pp_shutter_gate.sv
module fe_pp_shutter_gate #(
  parameter int CNT_W = 24
) (
  input  logic             run,
  input  logic [CNT_W-1:0] phase,
  input  logic [CNT_W-1:0] settle_q,
  input  logic [CNT_W-1:0] shut_q,
  output logic             shutter
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] close_at;
  logic             past_open;
  logic             before_close;

  // extra bit keeps settle + width from wrapping; the window end clips it
  assign close_at     = {1'b0, settle_q} + {1'b0, shut_q};
  assign past_open    = (phase >= settle_q);
  assign before_close = ({1'b0, phase} < close_at);
  assign shutter      = run && past_open && before_close;
endmodule

// File: rtl/fe_pulse_seq.sv
module fe_pulse_seq #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             train_start,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] settle_len,
  input  logic [CNT_W-1:0] shut_len,
  input  logic [CNT_W-1:0] win_len,
  output logic             bias_en,
  output logic             shutter,
  output logic             busy,
  output logic             overrun
);
  logic             rst_meta, rst_sync_n;
  logic             run;
  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] settle_q, shut_q, win_q;
  logic             start_req, load_en;
  logic             ovr_q, ovr_n, ovr_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign start_req = train_start && !run;
  assign load_en   = cfg_load && !run;

  fe_pp_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (load_en),
    .settle_in(settle_len),
    .shut_in  (shut_len),
    .win_in   (win_len),
    .settle_q (settle_q),
    .shut_q   (shut_q),
    .win_q    (win_q)
  );

  fe_pp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_req(start_req),
    .win_len_q(win_q),
    .run      (run),
    .phase    (phase)
  );

  fe_pp_shutter_gate #(.CNT_W(CNT_W)) u_gate (
    .run     (run),
    .phase   (phase),
    .settle_q(settle_q),
    .shut_q  (shut_q),
    .shutter (shutter)
  );

  assign ovr_ce = train_start && run;
  assign ovr_n  = 1'b1;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ovr_q <= 1'b0;
    end else if (ovr_ce) begin
      ovr_q <= ovr_n;
    end
  end

  assign bias_en = run;
  assign busy    = run;
  assign overrun = ovr_q;
endmodule

// File: rtl/fe_pp_checker.sv
module fe_pp_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             train_start,
  input logic             bias_en,
  input logic             shutter,
  input logic             busy,
  input logic             overrun,
  input logic [CNT_W-1:0] settle_q,
  input logic [CNT_W-1:0] shut_q,
  input logic [CNT_W-1:0] win_q
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!bias_en && !shutter && !busy && !overrun));

  // R10
  shutter_in_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutter |-> bias_en);

  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (train_start && busy) |=> overrun);

  // R6
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R2
  bias_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bias_en) |-> $past(train_start));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(settle_q) && $stable(shut_q) && $stable(win_q)));
endmodule

bind fe_pulse_seq fe_pp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .train_start(train_start),
  .bias_en    (bias_en),
  .shutter    (shutter),
  .busy       (busy),
  .overrun    (overrun),
  .settle_q   (settle_q),
  .shut_q     (shut_q),
  .win_q      (win_q)
);

// File: tb/fe_pulse_seq_test.sv
module fe_pulse_seq_test;
  localparam int CW = 24;
  localparam int NV = 7;
  // each row: settle, shutter width, window
  localparam int VEC [NV][3] = '{
    '{3, 4, 12},   // R3 plain
    '{5, 10, 9},   // R4 clipped
    '{0, 3, 6},    // R3 zero settle
    '{2, 0, 8},    // R5 empty width
    '{9, 3, 7},    // R5 settle past window
    '{0, 0, 0},    // R2 zero window
    '{0, 20, 1}    // R4 single-cycle window
  };

  logic          clk, rst_n, train_start, cfg_load;
  logic [CW-1:0] settle_len, shut_len, win_len;
  logic          bias_en, shutter, busy, overrun;
  int            n_chk, n_fail;
  bit            done;

  fe_pulse_seq #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .train_start(train_start), .cfg_load(cfg_load),
    .settle_len(settle_len), .shut_len(shut_len), .win_len(win_len),
    .bias_en(bias_en), .shutter(shutter), .busy(busy), .overrun(overrun)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // call at a negedge; capture happens on the next posedge
  task automatic load_cfg(input int d, input int s, input int w);
    cfg_load = 1'b1; settle_len = CW'(d); shut_len = CW'(s); win_len = CW'(w);
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // call at a negedge; pulses start, then compares each cycle to the model
  task automatic run_seq(input int d, input int s, input int w, input string req);
    int weff;
    weff = (w == 0) ? 1 : w;
    train_start = 1'b1;
    @(negedge clk);
    train_start = 1'b0;
    for (int i = 0; i <= weff; i++) begin
      bit eb, es;
      eb = (i < weff);
      es = eb && (i >= d) && (i < d + s);
      chk({bias_en, shutter, busy} == {eb, es, eb}, req,
          int'({bias_en, shutter, busy}), int'({eb, es, eb}));
      if (i < weff) @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk({bias_en, shutter, busy, overrun} == 4'b0, "R1 in reset",
        int'({bias_en, shutter, busy, overrun}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({bias_en, shutter, busy, overrun} == 4'b0, "R1 after release",
        int'({bias_en, shutter, busy, overrun}), 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    train_start = 1'b0; cfg_load = 1'b0;
    settle_len = '0; shut_len = '0; win_len = '0;
    do_reset();

    // R1: no activity without a strobe
    repeat (5) @(negedge clk);
    chk(!bias_en && !busy, "R1 waits for strobe", int'(bias_en), 0);

    for (int v = 0; v < NV; v++) begin
      load_cfg(VEC[v][0], VEC[v][1], VEC[v][2]);
      run_seq(VEC[v][0], VEC[v][1], VEC[v][2], "R2/R3/R4/R5 vector");
      @(negedge clk);
    end

    // R8: load and start in the same idle cycle
    cfg_load = 1'b1; settle_len = 24'd1; shut_len = 24'd2; win_len = 24'd5;
    run_seq(1, 2, 5, "R8 load with start");
    cfg_load = 1'b0;

    // R9: back-to-back trains, no overrun
    run_seq(1, 2, 5, "R9 back to back");
    chk(!overrun, "R9 no overrun", int'(overrun), 0);

    // R6 and R7: strobe and load while busy
    @(negedge clk);
    load_cfg(2, 3, 10);
    train_start = 1'b1;
    @(negedge clk);
    train_start = 1'b0;
    for (int i = 0; i <= 10; i++) begin
      bit eb, es;
      eb = (i < 10);
      es = (i >= 2) && (i < 5);
      chk({bias_en, shutter} == {eb, es}, "R6 sequence not restarted",
          int'({bias_en, shutter}), int'({eb, es}));
      if (i == 3) begin
        chk(!overrun, "R6 overrun before", int'(overrun), 0);
        train_start = 1'b1;
      end
      if (i == 4) begin
        train_start = 1'b0;
        chk(overrun, "R6 overrun set", int'(overrun), 1);
      end
      if (i == 6) begin
        cfg_load = 1'b1; settle_len = 24'd0; shut_len = 24'd1; win_len = 24'd4;
      end
      if (i == 7) cfg_load = 1'b0;
      if (i < 10) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(overrun, "R6 overrun sticky", int'(overrun), 1);
    // R7: earlier lengths still in force
    run_seq(2, 3, 10, "R7 load while busy ignored");

    // R1: reset clears sticky flag
    @(negedge clk);
    do_reset();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule